// File: doc/BRIEF.md
# Two-Cycle SDRAM Command Launcher

This block sits between a memory controller and the command/address pins of an SDRAM-style device running in two-cycle (2T) command mode. The controller offers one request at a time (read or write, an address and an on-die-termination flag) over a valid/ready handshake. Each accepted request becomes a two-cycle window on the memory bus. The address, the row/column/write strobes and the termination flag stay constant for both cycles. Chip select is driven low only in the second cycle.

Every request travels through a fixed-length pipeline. The bus outputs are registered on the falling clock edge, so the device sees them centred around its rising sampling edge. When no request is taken, the window carries a no-operation command. A separate read-flag shift register follows each read through the pipeline and the programmed CAS latency. It produces a one-cycle strobe in the cycle the read data is due back from the device.

Top module: `cmd2t_launch`

## Requirements
- R1: Within each command window, mem_addr, mem_odt and {mem_ras_n, mem_cas_n, mem_we_n} hold the same value at both rising edges the device samples.
- R2: mem_cs_n is low at the second sampled edge of a command window only, and never low on two consecutive sampled edges.
- R3: The bus outputs change only on the falling clock edge, never across a rising edge.
- R4: A request accepted at rising edge t is sampled by the device at rising edges t+LAUNCH_DELAY (cs_n high) and t+LAUNCH_DELAY+1 (cs_n low). The default LAUNCH_DELAY is 6.
- R5: The command is encoded on {cs_n, ras_n, cas_n, we_n}: READ is 0101 and WRITE is 0100 in the chip-select cycle. No other strobe pattern than 111 (NOP), 101 or 100 ever appears on {ras_n, cas_n, we_n}.
- R6: Any bus edge that does not belong to an accepted request's window carries NOP (ras_n, cas_n and we_n all high).
- R7: req_ready is high in every second cycle only, so that at most one request is taken per two cycles. A request held valid is taken at the next ready edge with no further gap.
- R8: Requests reach the bus in the order they were accepted, with their own addresses. For example, back-to-back reads at 0x0, 0x4, 0x8, 0xC and 0x10 appear in that order.
- R9: rd_valid is a one-cycle pulse per read. It is high exactly after rising edge t+LAUNCH_DELAY+CAS_LAT for a read accepted at edge t, and it is never raised for writes. The default CAS_LAT is 3.
- R10: While the synchronous active-high rst is high, the bus shows cs_n high with NOP strobes and address 0, rd_valid is low and req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Controller offers a request |
| req_ready | output | 1 | Request taken at this rising edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_odt | input | 1 | Termination flag for the request |
| mem_cs_n | output | 1 | Chip select, active low, 1T strobe |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_odt | output | 1 | On-die termination |
| mem_addr | output | ADDR_W | Address bus |
| rd_valid | output | 1 | Read data due this cycle |

## Verification
A phase error in the two-cycle slot counter would first show on req_ready, one cycle after it happened. LAUNCH_DELAY cycles later, chip select would fall on the wrong edge of the window. A stage lost or added in the delay line would shift every window by a whole cycle, so the first checked request after reset would already mismatch on cs_n and address. A wrong tap in the read-flag shift register would move rd_valid off its expected edge on the very first read, while writes would still look correct on the bus. The bench therefore predicts every bus edge and every rd_valid cycle, and it checks idle edges as strictly as busy ones.

// File: rtl/cmd2t_pkg.sv
package cmd2t_pkg;

    typedef enum logic [1:0] {
        K_NOP = 2'd0,
        K_RD  = 2'd1,
        K_WR  = 2'd2
    } kind_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    // Strobe pattern driven for each command kind (chip select handled apart)
    function automatic pins_t kind_pins(kind_e k);
        pins_t p;
        case (k)
            K_RD:    p = '{ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            K_WR:    p = '{ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
            default: p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cmd2t_accept.sv
module cmd2t_accept
    import cmd2t_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_odt,
    output kind_e             win_kind,
    output logic              win_cs_en,
    output logic              win_odt,
    output logic [ADDR_W-1:0] win_addr,
    output logic              rd_take
);

    typedef struct packed {
        logic              slot2;
        kind_e             kind;
        logic              odt;
        logic [ADDR_W-1:0] addr;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d       = acc_q;
        acc_d.slot2 = ~acc_q.slot2;
        if (acc_q.slot2) begin
            if (req_valid) begin
                acc_d.kind = req_write ? K_WR : K_RD;
                acc_d.addr = req_addr;
                acc_d.odt  = req_odt;
            end else begin
                acc_d.kind = K_NOP;
                acc_d.addr = '0;
                acc_d.odt  = 1'b0;
            end
        end
        if (rst) begin
            acc_d.slot2 = 1'b0;
            acc_d.kind  = K_NOP;
            acc_d.addr  = '0;
            acc_d.odt   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        acc_q <= acc_d;
    end

    assign req_ready = acc_q.slot2;
    assign rd_take   = req_valid & acc_q.slot2 & ~req_write;
    assign win_kind  = acc_q.kind;
    assign win_cs_en = acc_q.slot2;
    assign win_odt   = acc_q.odt;
    assign win_addr  = acc_q.addr;

    // R7
    ready_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // R7
    ready_return_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

    // R1
    window_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !win_cs_en |=> ($stable(win_addr) && $stable(win_kind) && $stable(win_odt)));

endmodule

// File: rtl/cmd2t_delay.sv
module cmd2t_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [DEPTH];
    logic [W-1:0] stg_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_comb stg_d[i] = rst ? '0 : din;
            end else begin : g_body
                always_comb stg_d[i] = rst ? '0 : stg_q[i-1];
            end
            always_ff @(posedge clk) stg_q[i] <= stg_d[i];
        end
    endgenerate

    assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/cmd2t_drive.sv
module cmd2t_drive
    import cmd2t_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  kind_e             in_kind,
    input  logic              in_cs_en,
    input  logic              in_odt,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic              mem_odt,
    output logic [ADDR_W-1:0] mem_addr
);

    typedef struct packed {
        logic              cs_n;
        pins_t             pins;
        logic              odt;
        logic [ADDR_W-1:0] addr;
    } bus_t;

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d.cs_n = ~in_cs_en;
        bus_d.pins = kind_pins(in_kind);
        bus_d.odt  = in_odt;
        bus_d.addr = in_addr;
        if (rst) begin
            bus_d.cs_n = 1'b1;
            bus_d.pins = kind_pins(K_NOP);
            bus_d.odt  = 1'b0;
            bus_d.addr = '0;
        end
    end

    // Falling-edge launch centres the bus on the device's rising sample edge
    always_ff @(negedge clk) begin
        bus_q <= bus_d;
    end

    assign mem_cs_n  = bus_q.cs_n;
    assign mem_ras_n = bus_q.pins.ras_n;
    assign mem_cas_n = bus_q.pins.cas_n;
    assign mem_we_n  = bus_q.pins.we_n;
    assign mem_odt   = bus_q.odt;
    assign mem_addr  = bus_q.addr;

    // R2
    cs_one_t_chk: assert property (@(negedge clk) disable iff (rst)
        !mem_cs_n |=> mem_cs_n);

    // R1
    bus_hold_chk: assert property (@(negedge clk) disable iff (rst)
        !mem_cs_n |-> ($stable(mem_addr) && $stable(mem_odt)
                       && $stable({mem_ras_n, mem_cas_n, mem_we_n})));

    // R5
    cmd_legal_chk: assert property (@(negedge clk) disable iff (rst)
        ({mem_ras_n, mem_cas_n, mem_we_n} == 3'b111) ||
        ({mem_ras_n, mem_cas_n, mem_we_n} == 3'b101) ||
        ({mem_ras_n, mem_cas_n, mem_we_n} == 3'b100));

endmodule

// File: rtl/cmd2t_rdtrack.sv
module cmd2t_rdtrack #(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_take,
    output logic rd_valid
);

    logic [LEN-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[LEN-2:0], rd_take};
        if (rst) sr_d = '0;
    end

    always_ff @(posedge clk) begin
        sr_q <= sr_d;
    end

    assign rd_valid = sr_q[LEN-1];

    // R9
    rdv_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R9
    rd_density_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(sr_q) <= (LEN + 1) / 2);

    // R10
    rdv_reset_chk: assert property (@(posedge clk)
        rst |=> !rd_valid);

endmodule

// File: rtl/cmd2t_launch.sv
module cmd2t_launch
    import cmd2t_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int LAUNCH_DELAY = 6,
    parameter int CAS_LAT      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_odt,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic              mem_odt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_valid
);

    localparam int SLOT_W = ADDR_W + 4;
    localparam int DEPTH  = (LAUNCH_DELAY > 1) ? LAUNCH_DELAY - 1 : 1;
    localparam int RD_LEN = LAUNCH_DELAY + CAS_LAT + 1;

    kind_e             w_kind;
    logic              w_cs_en, w_odt, rd_take;
    logic [ADDR_W-1:0] w_addr;
    logic [SLOT_W-1:0] slot_in, slot_out;

    cmd2t_accept #(.ADDR_W(ADDR_W)) u_accept (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_odt   (req_odt),
        .win_kind  (w_kind),
        .win_cs_en (w_cs_en),
        .win_odt   (w_odt),
        .win_addr  (w_addr),
        .rd_take   (rd_take)
    );

    assign slot_in = {w_kind, w_cs_en, w_odt, w_addr};

    cmd2t_delay #(.W(SLOT_W), .DEPTH(DEPTH)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (slot_in),
        .dout (slot_out)
    );

    cmd2t_drive #(.ADDR_W(ADDR_W)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .in_kind   (kind_e'(slot_out[SLOT_W-1 -: 2])),
        .in_cs_en  (slot_out[ADDR_W+1]),
        .in_odt    (slot_out[ADDR_W]),
        .in_addr   (slot_out[ADDR_W-1:0]),
        .mem_cs_n  (mem_cs_n),
        .mem_ras_n (mem_ras_n),
        .mem_cas_n (mem_cas_n),
        .mem_we_n  (mem_we_n),
        .mem_odt   (mem_odt),
        .mem_addr  (mem_addr)
    );

    cmd2t_rdtrack #(.LEN(RD_LEN)) u_rdtrack (
        .clk      (clk),
        .rst      (rst),
        .rd_take  (rd_take),
        .rd_valid (rd_valid)
    );

endmodule

// File: tb/cmd2t_launch_test.sv
module cmd2t_launch_test;

    localparam int AW = 16;
    localparam int LD = 6;
    localparam int CL = 3;
    localparam int NE = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_odt = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_odt, rd_valid;
    logic [AW-1:0] mem_addr;

    always #5 clk = ~clk;

    cmd2t_launch #(.ADDR_W(AW), .LAUNCH_DELAY(LD), .CAS_LAT(CL)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_odt(req_odt),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_odt(mem_odt), .mem_addr(mem_addr),
        .rd_valid(rd_valid)
    );

    int total = 0, bad = 0, cyc = 0, start = -1;
    bit done = 1'b0;
    bit          ex_win [NE];
    bit          ex_cs  [NE];
    logic [2:0]  ex_pin [NE];
    logic [AW-1:0] ex_adr [NE];
    bit          ex_odt [NE];
    bit          ex_rdv [NE];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (edge %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic logic [2:0] strobes(bit wr);
        return wr ? 3'b100 : 3'b101;
    endfunction

    // Present one request before the next rising edge; report whether it is taken
    task automatic drive(bit v, bit wr, logic [AW-1:0] a, bit o, output bit taken);
        int t;
        @(negedge clk);
        req_valid = v; req_write = wr; req_addr = a; req_odt = o;
        #1;
        taken = v && req_ready;
        if (taken) begin
            t = cyc + 1;
            if (t + LD + CL + 1 < NE) begin
                // R4: device samples at t+LD (cs high) and t+LD+1 (cs low)
                ex_win[t+LD] = 1; ex_cs[t+LD] = 1; ex_pin[t+LD] = strobes(wr);
                ex_adr[t+LD] = a; ex_odt[t+LD] = o;
                ex_win[t+LD+1] = 1; ex_cs[t+LD+1] = 0; ex_pin[t+LD+1] = strobes(wr);
                ex_adr[t+LD+1] = a; ex_odt[t+LD+1] = o;
                if (!wr) ex_rdv[t+LD+CL] = 1;
            end
        end
    endtask

    // Monitor: +3 after a rising edge shows what the device sampled there
    initial begin
        logic [AW+4:0] snap;
        bit snap_ok;
        bit prev_rdy;
        snap_ok = 0; prev_rdy = 0;
        forever begin
            @(posedge clk);
            #3;
            if (rst) begin
                if (cyc >= 2) begin
                    // R10 reset state
                    check(mem_cs_n == 1'b1, "R10", "cs_n in reset", mem_cs_n, 1);
                    check({mem_ras_n, mem_cas_n, mem_we_n} == 3'b111, "R10", "strobes in reset",
                          {mem_ras_n, mem_cas_n, mem_we_n}, 3'b111);
                    check(mem_addr == '0, "R10", "addr in reset", mem_addr, 0);
                    check(rd_valid == 1'b0, "R10", "rd_valid in reset", rd_valid, 0);
                    check(req_ready == 1'b0, "R10", "ready in reset", req_ready, 0);
                end
                snap_ok = 0;
            end else if (start >= 0 && cyc >= start && cyc < NE) begin
                if (snap_ok)   // R3: nothing changes across a rising edge
                    check(snap == {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_odt, mem_addr},
                          "R3", "bus moved at rising edge",
                          {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_odt, mem_addr}, snap);
                if (cyc > start)  // R7 ready alternates
                    check(req_ready != prev_rdy, "R7", "ready alternation", req_ready, !prev_rdy);
                prev_rdy = req_ready;
                if (ex_win[cyc]) begin
                    check(mem_cs_n == ex_cs[cyc], "R2 R4", "cs_n", mem_cs_n, ex_cs[cyc]);
                    check({mem_ras_n, mem_cas_n, mem_we_n} == ex_pin[cyc], "R5", "strobes",
                          {mem_ras_n, mem_cas_n, mem_we_n}, ex_pin[cyc]);
                    check(mem_addr == ex_adr[cyc], "R8", "address", mem_addr, ex_adr[cyc]);
                    check(mem_odt == ex_odt[cyc], "R1", "odt", mem_odt, ex_odt[cyc]);
                end else begin
                    check({mem_ras_n, mem_cas_n, mem_we_n} == 3'b111, "R6", "idle strobes",
                          {mem_ras_n, mem_cas_n, mem_we_n}, 3'b111);
                end
                check(rd_valid == ex_rdv[cyc], "R9", "rd_valid", rd_valid, ex_rdv[cyc]);
                #4;
                snap = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_odt, mem_addr};
                snap_ok = 1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit tk;
        int idx;
        void'($urandom(32'h5eed_c0de));
        repeat (5) @(negedge clk);
        #1 rst = 1'b0;
        start = cyc + 1;

        // R8 directed: five back-to-back reads, step 4 from 0
        idx = 0;
        while (idx < 5) begin
            drive(1, 0, AW'(idx * 4), 0, tk);
            if (tk) idx++;
        end
        repeat (20) drive(0, 0, '0, 0, tk);

        // back-to-back writes with termination on
        idx = 0;
        while (idx < 6) begin
            drive(1, 1, AW'(16'h1000 + idx), 1, tk);
            if (tk) idx++;
        end
        repeat (15) drive(0, 0, '0, 0, tk);

        // constrained random traffic
        for (int n = 0; n < 1500; n++) begin
            drive(($urandom % 3) != 0, $urandom % 2, AW'($urandom), $urandom % 2, tk);
        end

        // drain
        repeat (LD + CL + 6) drive(0, 0, '0, 0, tk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule